// File: doc/BRIEF.md
# ISDN B-Channel Time-Slot Port

This block connects one 8-bit voice sample stream to a 2B+D serial frame. In every frame it sends one transmit byte in either the first or the second B channel, and it picks out the byte that the far end placed in that same channel. It has no clock of its own for the line. The data clock, the frame sync and the serial input are sampled on the system clock, and line edges are detected from those samples. Each line clock period must therefore last several system clock cycles.

Two slot formats are supported.

- **Half-rate format:** each bit occupies two data-clock periods. B1 fills the first 16 periods after sync and B2 fills the next 16.
- **Full-rate format:** each bit occupies one data-clock period, and the sync pulse is one period long. B1 starts one rising edge after the sync edge and B2 starts eleven rising edges after it.

A static format pin chooses the format, and a static channel pin chooses the B channel. Both pins are qualified over whole frames before they take effect. The serial output comes with an enable, which the pad ring turns into a high-impedance driver. The received byte comes with a one-cycle valid strobe.

Top module: `isdn_bslot_port`

## Requirements
- R1: After reset, and until the first sync edge, the output enable and the receive strobe stay low and the serial output is 0.
- R2: Format pin low selects the half-rate format and high selects the full-rate format. Channel pin low selects B1 and high selects B2. The chosen channel applies to both directions.
- R3: A frame start is a data-clock rising edge at which sync is high after being low at the previous rising edge. The pins are sampled at every frame start. A new pin setting takes effect only at the third consecutive frame start that sees it unchanged. The frames before that use the old setting, and a setting seen at fewer frame starts is discarded.
- R4: Half-rate transmit: count the frame-start edge as rising edge 0. Bit k of the byte (k=0 is the MSB) is driven from rising edge s+2k for two clock periods, where s=0 for B1 and s=16 for B2.
- R5: Half-rate receive: bit k is sampled at rising edge s+2k+1, the second edge of its bit cell.
- R6: Full-rate transmit: bit k is driven from rising edge s+k, where s=1 for B1 and s=11 for B2.
- R7: Full-rate receive: bit k is sampled at the falling edge that follows rising edge s+k.
- R8: The output enable is high only during the selected slot: 16 clock periods in the half-rate format and 8 in the full-rate format. It is low at all other times, including the slot of the other B channel.
- R9: After the last bit of the slot, the received byte is presented MSB first with a valid strobe lasting exactly one system cycle. Serial input outside the slot has no effect.
- R10: The transmit byte is captured at the frame-start edge. Changes to the transmit input later in the frame do not affect that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times faster than the data clock |
| rst | input | 1 | Synchronous active-high reset |
| dclk_i | input | 1 | Line data clock |
| fsync_i | input | 1 | Line frame sync |
| rxd_i | input | 1 | Serial receive data |
| fmt_sel_i | input | 1 | Format pin: 0 half-rate, 1 full-rate |
| chan_sel_i | input | 1 | Channel pin: 0 B1, 1 B2 |
| tx_sample_i | input | 8 | Byte to transmit in the next frame |
| txd_o | output | 1 | Serial transmit data |
| txd_oe_o | output | 1 | Transmit driver enable; low means high impedance |
| rx_sample_o | output | 8 | Received byte |
| rx_valid_o | output | 1 | One-cycle strobe for rx_sample_o |

## Verification
The hardest case to reach is the frame-level qualification of the pins. It only shows up when a change is held across frames and the slot positions are watched in the frames on both sides of the switch. The stimulus changes the pins between frames and keeps checking the enable window and the data bits against the old setting for two frames, then against the new one. It also flips the format pin for a single frame and then restores it, and it confirms that no frame moves its slot as a result. Every frame fills the other channel's slot with a decoy pattern and rewrites the transmit input mid-frame. Leakage from either source would then show up as a wrong byte.

// File: rtl/bslot_pkg.sv
`timescale 1ns/1ps
package bslot_pkg;

    localparam int SLOT_BITS   = 8;
    localparam int IDX_W       = $clog2(SLOT_BITS);
    localparam int POS_W       = 8;
    localparam int GCI_CELLS   = 2;
    localparam int IDL_CELLS   = 1;
    localparam int IDL_B1_EDGE = 1;
    localparam int IDL_B2_EDGE = 11;

    typedef enum logic { FMT_GCI = 1'b0, FMT_IDL = 1'b1 } fmt_e;
    typedef enum logic { CH_B1 = 1'b0, CH_B2 = 1'b1 } chan_e;

    typedef struct packed {
        fmt_e  fmt;
        chan_e chan;
    } slot_cfg_t;

    localparam slot_cfg_t CFG_RESET = '{fmt: FMT_GCI, chan: CH_B1};

    typedef struct packed {
        logic rise;
        logic fall;
        logic frame;
        logic rxd;
    } line_evt_t;

    typedef struct packed {
        logic             hit;
        logic             half;
        logic [IDX_W-1:0] idx;
    } slot_pos_t;

    function automatic int cells_of(fmt_e f);
        return (f == FMT_GCI) ? GCI_CELLS : IDL_CELLS;
    endfunction

    function automatic int first_edge(slot_cfg_t c);
        if (c.fmt == FMT_GCI)
            return (c.chan == CH_B2) ? SLOT_BITS * GCI_CELLS : 0;
        return (c.chan == CH_B2) ? IDL_B2_EDGE : IDL_B1_EDGE;
    endfunction

    // Map a rising-edge position to slot membership and bit index.
    function automatic slot_pos_t locate(slot_cfg_t c, logic [POS_W-1:0] pos);
        slot_pos_t r;
        int off;
        int span;
        off    = int'(pos) - first_edge(c);
        span   = SLOT_BITS * cells_of(c.fmt);
        r.hit  = (off >= 0) && (off < span);
        r.idx  = r.hit ? IDX_W'(off / cells_of(c.fmt)) : '0;
        r.half = r.hit && (c.fmt == FMT_GCI) && ((off % 2) == 1);
        return r;
    endfunction

endpackage

// File: rtl/bslot_line_sync.sv
`timescale 1ns/1ps
module bslot_line_sync
    import bslot_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      dclk_i,
    input  logic      fsync_i,
    input  logic      rxd_i,
    output line_evt_t evt_o
);

    logic dclk_s, dclk_d, fs_s, fs_at_rise, rxd_s;
    logic rise_w;

    assign rise_w = dclk_s & ~dclk_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            dclk_s     <= 1'b0;
            dclk_d     <= 1'b0;
            fs_s       <= 1'b0;
            rxd_s      <= 1'b0;
            fs_at_rise <= 1'b0;
        end else begin
            dclk_s <= dclk_i;
            dclk_d <= dclk_s;
            fs_s   <= fsync_i;
            rxd_s  <= rxd_i;
            if (rise_w)
                fs_at_rise <= fs_s;
        end
    end

    always_comb begin
        evt_o.rise  = rise_w;
        evt_o.fall  = ~dclk_s & dclk_d;
        evt_o.frame = rise_w & fs_s & ~fs_at_rise;
        evt_o.rxd   = rxd_s;
    end

endmodule

// File: rtl/bslot_cfg_qual.sv
`timescale 1ns/1ps
module bslot_cfg_qual
    import bslot_pkg::*;
#(
    parameter int QUAL_FRAMES = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      frame_i,
    input  logic      fmt_sel_i,
    input  logic      chan_sel_i,
    output slot_cfg_t cfg_o
);

    localparam int QW = $clog2(QUAL_FRAMES + 1);
    localparam logic [QW-1:0] SEEN_FULL = QW'(QUAL_FRAMES);

    slot_cfg_t       pin_q, cand, active;
    logic [QW-1:0]   seen;
    logic            qualified;

    assign qualified = (pin_q == cand) && (seen == SEEN_FULL);
    assign cfg_o     = (frame_i && qualified) ? pin_q : active;

    always_ff @(posedge clk) begin
        if (rst) begin
            pin_q  <= CFG_RESET;
            cand   <= CFG_RESET;
            active <= CFG_RESET;
            seen   <= SEEN_FULL;
        end else begin
            pin_q <= '{fmt: fmt_e'(fmt_sel_i), chan: chan_e'(chan_sel_i)};
            if (frame_i) begin
                active <= cfg_o;
                if (pin_q != cand) begin
                    cand <= pin_q;
                    seen <= QW'(1);
                end else if (seen != SEEN_FULL) begin
                    seen <= seen + 1'b1;
                end
            end
        end
    end

    // R3
    cfg_switch_chk: assert property (@(posedge clk) disable iff (rst)
        (active != $past(active)) |-> (active == cand && seen == SEEN_FULL && $past(frame_i)));

endmodule

// File: rtl/bslot_tx_timer.sv
`timescale 1ns/1ps
module bslot_tx_timer
    import bslot_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 rise_i,
    input  logic                 frame_i,
    input  slot_cfg_t            cfg_i,
    input  logic [SLOT_BITS-1:0] sample_i,
    output logic                 txd_o,
    output logic                 oe_o,
    output logic [CNT_W-1:0]     pos_o,
    output slot_cfg_t            frm_cfg_o,
    output logic [CNT_W-1:0]     rise_pos_o,
    output slot_cfg_t            rise_cfg_o
);

    localparam logic [CNT_W-1:0] POS_MAX = '1;

    logic [CNT_W-1:0]     pos, pos_nx;
    slot_cfg_t            frm_cfg, cfg_nx;
    logic [SLOT_BITS-1:0] txbuf, buf_nx;
    slot_pos_t            loc;

    always_comb begin
        if (frame_i)
            pos_nx = '0;
        else if (pos == POS_MAX)
            pos_nx = POS_MAX;
        else
            pos_nx = pos + 1'b1;
        cfg_nx = frame_i ? cfg_i : frm_cfg;
        buf_nx = frame_i ? sample_i : txbuf;
        loc    = locate(cfg_nx, POS_W'(pos_nx));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pos     <= POS_MAX;
            frm_cfg <= CFG_RESET;
            txbuf   <= '0;
            oe_o    <= 1'b0;
            txd_o   <= 1'b0;
        end else if (rise_i) begin
            pos     <= pos_nx;
            frm_cfg <= cfg_nx;
            txbuf   <= buf_nx;
            oe_o    <= loc.hit;
            txd_o   <= loc.hit ? buf_nx[IDX_W'(SLOT_BITS - 1) - loc.idx] : 1'b0;
        end
    end

    assign pos_o      = pos;
    assign frm_cfg_o  = frm_cfg;
    assign rise_pos_o = pos_nx;
    assign rise_cfg_o = cfg_nx;

    // R8
    frame_start_oe_chk: assert property (@(posedge clk) disable iff (rst)
        (rise_i && frame_i) |=> (oe_o == (frm_cfg.fmt == FMT_GCI && frm_cfg.chan == CH_B1)));

    // R4
    gci_half_cell_chk: assert property (@(posedge clk) disable iff (rst)
        (rise_i && cfg_nx.fmt == FMT_GCI && loc.half) |=> $stable(txd_o));

    // R6
    oe_on_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(oe_o) |-> $past(rise_i));

endmodule

// File: rtl/bslot_rx_lane.sv
`timescale 1ns/1ps
module bslot_rx_lane
    import bslot_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 rise_i,
    input  logic                 fall_i,
    input  logic                 rxd_i,
    input  logic [CNT_W-1:0]     pos_i,
    input  slot_cfg_t            frm_cfg_i,
    input  logic [CNT_W-1:0]     rise_pos_i,
    input  slot_cfg_t            rise_cfg_i,
    output logic [SLOT_BITS-1:0] byte_o,
    output logic                 valid_o
);

    slot_pos_t            at_rise, at_fall;
    logic                 take;
    logic [IDX_W-1:0]     bidx;
    logic [SLOT_BITS-2:0] sh;

    always_comb begin
        at_rise = locate(rise_cfg_i, POS_W'(rise_pos_i));
        at_fall = locate(frm_cfg_i, POS_W'(pos_i));
        take    = 1'b0;
        bidx    = '0;
        if (rise_i && rise_cfg_i.fmt == FMT_GCI && at_rise.half) begin
            take = 1'b1;
            bidx = at_rise.idx;
        end else if (fall_i && frm_cfg_i.fmt == FMT_IDL && at_fall.hit) begin
            take = 1'b1;
            bidx = at_fall.idx;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sh      <= '0;
            byte_o  <= '0;
            valid_o <= 1'b0;
        end else begin
            valid_o <= 1'b0;
            if (take) begin
                if (bidx == IDX_W'(SLOT_BITS - 1)) begin
                    byte_o  <= {sh, rxd_i};
                    valid_o <= 1'b1;
                end else begin
                    sh <= {sh[SLOT_BITS-3:0], rxd_i};
                end
            end
        end
    end

    // R9
    strobe_width_chk: assert property (@(posedge clk) disable iff (rst)
        valid_o |=> !valid_o);

    // R7
    idl_fall_sample_chk: assert property (@(posedge clk) disable iff (rst)
        (valid_o && frm_cfg_i.fmt == FMT_IDL) |-> $past(fall_i));

endmodule

// File: rtl/isdn_bslot_port.sv
`timescale 1ns/1ps
module isdn_bslot_port
    import bslot_pkg::*;
#(
    parameter int CNT_W       = 6,
    parameter int QUAL_FRAMES = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 dclk_i,
    input  logic                 fsync_i,
    input  logic                 rxd_i,
    input  logic                 fmt_sel_i,
    input  logic                 chan_sel_i,
    input  logic [SLOT_BITS-1:0] tx_sample_i,
    output logic                 txd_o,
    output logic                 txd_oe_o,
    output logic [SLOT_BITS-1:0] rx_sample_o,
    output logic                 rx_valid_o
);

    line_evt_t        evt;
    slot_cfg_t        cfg_now, frm_cfg, rise_cfg;
    logic [CNT_W-1:0] pos, rise_pos;

    bslot_line_sync u_line (
        .clk     (clk),
        .rst     (rst),
        .dclk_i  (dclk_i),
        .fsync_i (fsync_i),
        .rxd_i   (rxd_i),
        .evt_o   (evt)
    );

    bslot_cfg_qual #(.QUAL_FRAMES(QUAL_FRAMES)) u_qual (
        .clk        (clk),
        .rst        (rst),
        .frame_i    (evt.frame),
        .fmt_sel_i  (fmt_sel_i),
        .chan_sel_i (chan_sel_i),
        .cfg_o      (cfg_now)
    );

    bslot_tx_timer #(.CNT_W(CNT_W)) u_tx (
        .clk        (clk),
        .rst        (rst),
        .rise_i     (evt.rise),
        .frame_i    (evt.frame),
        .cfg_i      (cfg_now),
        .sample_i   (tx_sample_i),
        .txd_o      (txd_o),
        .oe_o       (txd_oe_o),
        .pos_o      (pos),
        .frm_cfg_o  (frm_cfg),
        .rise_pos_o (rise_pos),
        .rise_cfg_o (rise_cfg)
    );

    bslot_rx_lane #(.CNT_W(CNT_W)) u_rx (
        .clk        (clk),
        .rst        (rst),
        .rise_i     (evt.rise),
        .fall_i     (evt.fall),
        .rxd_i      (evt.rxd),
        .pos_i      (pos),
        .frm_cfg_i  (frm_cfg),
        .rise_pos_i (rise_pos),
        .rise_cfg_i (rise_cfg),
        .byte_o     (rx_sample_o),
        .valid_o    (rx_valid_o)
    );

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!txd_oe_o && !$past(evt.rise)) |-> !txd_o);

endmodule

// File: tb/isdn_bslot_port_tb.sv
`timescale 1ns/1ps
module isdn_bslot_port_tb;

    localparam int FRAME_LEN = 40;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       dclk = 1'b0, fsync = 1'b0, rxd = 1'b0;
    logic       fmt_sel = 1'b0, chan_sel = 1'b0;
    logic [7:0] tx_sample = 8'h00;
    logic       txd, txd_oe, rx_valid;
    logic [7:0] rx_sample;

    int         vecs = 0;
    int         errs = 0;
    bit         done = 1'b0;
    logic [7:0] exp_q[$];
    logic [7:0] mon_exp;

    always #2.5 clk = ~clk;

    isdn_bslot_port u_dut (
        .clk         (clk),
        .rst         (rst),
        .dclk_i      (dclk),
        .fsync_i     (fsync),
        .rxd_i       (rxd),
        .fmt_sel_i   (fmt_sel),
        .chan_sel_i  (chan_sel),
        .tx_sample_i (tx_sample),
        .txd_o       (txd),
        .txd_oe_o    (txd_oe),
        .rx_sample_o (rx_sample),
        .rx_valid_o  (rx_valid)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        vecs++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor: pops the scoreboard at every receive strobe (R9, R5, R7)
    always @(negedge clk) begin
        if (!rst && rx_valid) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R9 unexpected strobe", rx_sample, 0);
            end else begin
                mon_exp = exp_q.pop_front();
                chk(rx_sample == mon_exp, "R9 R5 R7 received byte", rx_sample, mon_exp);
            end
        end
    end

    // One frame; idl/b2 are the configuration the frame is expected to use
    task automatic run_frame(input bit idl, input bit b2, input logic [7:0] txb,
                             input logic [7:0] rxb);
        int first, cells, span, off, idx;
        bit in_slot;
        logic [7:0] decoy;
        string tag;
        first = idl ? (b2 ? 11 : 1) : (b2 ? 16 : 0);
        cells = idl ? 1 : 2;
        span  = 8 * cells;
        decoy = ~rxb ^ 8'h5A;
        tag   = idl ? "R6 R2 full-rate tx bit" : "R4 R2 half-rate tx bit";
        exp_q.push_back(rxb);
        tx_sample = txb;
        for (int n = 0; n < FRAME_LEN; n++) begin
            off     = n - first;
            in_slot = (off >= 0) && (off < span);
            idx     = in_slot ? off / cells : 0;
            @(negedge clk);
            dclk  = 1'b1;
            fsync = (n == 0);
            rxd   = in_slot ? rxb[7 - idx] : decoy[n % 8];
            if (n == 3) tx_sample = ~txb;   // R10: late change must not leak
            repeat (2) @(negedge clk);
            dclk = 1'b0;
            repeat (2) @(negedge clk);
            chk(txd_oe == in_slot, "R8 output enable window", txd_oe, in_slot);
            if (in_slot)
                chk(txd == txb[7 - idx], tag, txd, txb[7 - idx]);
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        // R1: quiet after reset and with a clock but no sync
        chk(txd_oe == 1'b0, "R1 enable after reset", txd_oe, 0);
        chk(txd == 1'b0, "R1 data after reset", txd, 0);
        chk(rx_valid == 1'b0, "R1 strobe after reset", rx_valid, 0);
        for (int n = 0; n < 6; n++) begin
            @(negedge clk);
            dclk = 1'b1;
            rxd  = n[0];
            repeat (2) @(negedge clk);
            dclk = 1'b0;
            repeat (2) @(negedge clk);
            chk(txd_oe == 1'b0, "R1 no sync yet", txd_oe, 0);
        end

        // half-rate B1 from reset
        run_frame(0, 0, 8'hA5, 8'h3C);
        run_frame(0, 0, 8'h0F, 8'hF0);
        // R3: switch to B2, two old frames then new
        chan_sel = 1'b1;
        run_frame(0, 0, 8'h81, 8'h7E);
        run_frame(0, 0, 8'h42, 8'hC3);
        run_frame(0, 1, 8'h96, 8'h69);
        run_frame(0, 1, 8'hFF, 8'h00);
        // full-rate B1
        fmt_sel = 1'b1; chan_sel = 1'b0;
        run_frame(0, 1, 8'h5A, 8'hA5);
        run_frame(0, 1, 8'h12, 8'h34);
        run_frame(1, 0, 8'hB7, 8'h4D);
        run_frame(1, 0, 8'h01, 8'h80);
        // full-rate B2
        chan_sel = 1'b1;
        run_frame(1, 0, 8'hC9, 8'h36);
        run_frame(1, 0, 8'h77, 8'h88);
        run_frame(1, 1, 8'hE1, 8'h1E);
        run_frame(1, 1, 8'h00, 8'hFF);
        // R3: a one-frame glitch on the format pin is discarded
        fmt_sel = 1'b0;
        run_frame(1, 1, 8'h6C, 8'h93);
        fmt_sel = 1'b1;
        run_frame(1, 1, 8'h2B, 8'hD4);
        run_frame(1, 1, 8'h9E, 8'h61);
        run_frame(1, 1, 8'h55, 8'hAA);
        // back to half-rate B1
        fmt_sel = 1'b0; chan_sel = 1'b0;
        run_frame(1, 1, 8'h3D, 8'hC2);
        run_frame(1, 1, 8'hF3, 8'h0C);
        run_frame(0, 0, 8'h8E, 8'h71);

        repeat (20) @(negedge clk);
        chk(exp_q.size() == 0, "R9 missing received bytes", exp_q.size(), 0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            vecs++;
            errs++;
            $display("FAIL watchdog R1..all actual=timeout expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
            $finish;
        end
    end

endmodule